// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Merger

This block gathers eight level-style interrupt request lines into one interrupt signal for a processor. It holds three 8-bit state registers: the latched requests, a per-line mask, and the set of levels now being serviced. A resolver picks the lowest-numbered unmasked request. When that request outranks everything already in service, the block raises its interrupt output.

The processor answers with two acknowledge strobes. The first strobe moves the winning request into the in-service set, and no vector is produced for it. The second strobe produces an 8-bit vector. The vector's upper five bits come from a base value written during setup, and its lower three bits hold the level number.

A two-address register port carries the setup word sequence, mask writes, the end-of-service command and the status reads. The block stays silent until the setup sequence is complete.

Top module: `irq_prio_merger`

## Requirements
- R1: After reset, intOut and vecValid are 0, the mask register reads 0x00 at regAddr 1, and regAddr 0 reads 0x00 when no request line is high.
- R2: Before a setup sequence completes, intOut stays 0 whatever the request lines do.
- R3: The request register samples irqIn on every clock. An unmasked request that outranks all levels in service drives intOut to 1 one clock after the line is seen high.
- R4: A mask bit of 1 at position i keeps request line i from raising intOut. A mask bit of 0 enables the line. A write to regAddr 1 after setup loads the mask register.
- R5: Line 0 has the highest priority and line 7 the lowest. A request raises intOut only if its level number is strictly below that of every level in service.
- R6: On the first acknowledge strobe, the winning request bit is cleared and the matching in-service bit is set. vecValid stays 0 for that strobe, and intOut falls on the next clock.
- R7: On the second acknowledge strobe, vecValid goes to 1 for exactly one clock on the next cycle. In that cycle vecData = {base[7:3], level}.
- R8: A command write to regAddr 0 with bit 4 = 0, bit 3 = 0 and bits 7:5 = 001 clears the lowest-numbered set bit of the in-service register.
- R9: A write to regAddr 0 with bit 4 = 1 starts setup, clears the mask and in-service registers, and resets the read selection to the request register.
- R10: In the first setup word, bit 1 = 0 means a third word follows and bit 0 = 1 means a fourth word follows. The second word is the vector base. Words 2 to 4 are writes to regAddr 1, and intOut may rise only after the last expected word.
- R11: Reading regAddr 1 returns the mask register. Reading regAddr 0 returns the request register, or the in-service register after a command write with bit 4 = 0, bit 3 = 1 and bits 1:0 = 11. Bits 1:0 = 10 select the request register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Request lines, line 0 highest priority |
| intOut | output | 1 | Interrupt toward the processor |
| ackStrobe | input | 1 | One-clock acknowledge strobe; two strobes per sequence |
| wrEn | input | 1 | Register write enable |
| regAddr | input | 1 | Register port address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational) |
| vecValid | output | 1 | Vector present on vecData |
| vecData | output | 8 | Interrupt vector |

## Verification
Each result has a fixed due time. Register reads are combinational, so they are due in the same cycle that regAddr is driven. A mask, setup or end-of-service write takes effect on intOut the cycle after the write strobe. A change on irqIn reaches intOut one cycle later. The vector appears one cycle after the second acknowledge strobe and is gone the cycle after that. The driver tags every expected value with its due cycle. The monitor compares values 1 ns before the next rising edge, only in that cycle, so a result that comes early or late is reported.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef struct packed {
    logic cfgStart;  // first setup word written
    logic baseWr;    // vector base captured
    logic maskWr;    // mask register load
    logic eoiClr;    // clear highest in-service level
    logic ackTake;   // first acknowledge strobe
    logic ackEmit;   // second acknowledge strobe
  } ctrlStrobeT;

  typedef enum logic [2:0] {
    CFG_OFF,
    CFG_WANT2,
    CFG_WANT3,
    CFG_WANT4,
    CFG_READY
  } cfgStateT;

endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             regAddr,
  input  logic [VEC_W-1:0] wrData,
  input  logic             ackStrobe,
  output ctrlStrobeT       st,
  output logic             armed,
  output logic             readIsr
);

  cfgStateT cfgState;
  logic     singleMode;
  logic     wantFour;
  logic     ackPhase;
  logic     cmdWr;
  logic     selWr;

  assign armed = (cfgState == CFG_READY);
  assign cmdWr = wrEn && !regAddr && !wrData[4];
  assign selWr = cmdWr && armed && wrData[3] && wrData[1];

  always_comb begin
    st = '0;
    st.cfgStart = wrEn && !regAddr && wrData[4];
    st.baseWr   = wrEn && regAddr && (cfgState == CFG_WANT2);
    st.maskWr   = wrEn && regAddr && armed;
    st.eoiClr   = cmdWr && armed && !wrData[3] && (wrData[7:5] == 3'b001);
    st.ackTake  = ackStrobe && armed && !ackPhase;
    st.ackEmit  = ackStrobe && armed && ackPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgState   <= CFG_OFF;
      singleMode <= 1'b1;
      wantFour   <= 1'b0;
      ackPhase   <= 1'b0;
      readIsr    <= 1'b0;
    end else if (st.cfgStart) begin
      cfgState   <= CFG_WANT2;
      singleMode <= wrData[1];
      wantFour   <= wrData[0];
      ackPhase   <= 1'b0;
      readIsr    <= 1'b0;
    end else begin
      if (wrEn && regAddr) begin
        unique case (cfgState)
          CFG_WANT2: cfgState <= !singleMode ? CFG_WANT3 :
                                 (wantFour ? CFG_WANT4 : CFG_READY);
          CFG_WANT3: cfgState <= wantFour ? CFG_WANT4 : CFG_READY;
          CFG_WANT4: cfgState <= CFG_READY;
          default:   cfgState <= cfgState;
        endcase
      end
      if (st.ackTake) ackPhase <= 1'b1;
      else if (st.ackEmit) ackPhase <= 1'b0;
      if (selWr) readIsr <= wrData[0];
    end
  end

  // R9: a new setup sequence disarms the block
  p_cfg_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.cfgStart |=> !armed);
  // R6: the first strobe opens the second phase
  p_take_opens_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.ackTake |=> ackPhase);
  // R7: the vector strobe closes the sequence
  p_emit_closes_phase_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.ackEmit |=> !ackPhase);

endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       st,
  input  logic             armed,
  input  logic             readIsr,
  input  logic             regAddr,
  input  logic [VEC_W-1:0] wrData,
  input  logic [N_IRQ-1:0] irqIn,
  output logic             intOut,
  output logic [N_IRQ-1:0] rdData,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecData
);

  localparam int LVL_W  = $clog2(N_IRQ);
  localparam int BASE_W = VEC_W - LVL_W;

  logic [N_IRQ-1:0]  irr, imr, isr, isrNext, pendQ;
  logic [LVL_W-1:0]  bestLvl, svcLvl, takenLvl;
  logic              bestHit, svcHit, qualHit;
  logic [BASE_W-1:0] vecBase;

  assign pendQ = irr & ~imr;

  // lowest set index wins: scan from the top down
  always_comb begin
    bestLvl = '0;
    bestHit = 1'b0;
    svcLvl  = '0;
    svcHit  = 1'b0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        bestLvl = LVL_W'(i);
        bestHit = 1'b1;
      end
      if (isr[i]) begin
        svcLvl = LVL_W'(i);
        svcHit = 1'b1;
      end
    end
  end

  assign qualHit = bestHit && (!svcHit || (bestLvl < svcLvl));
  assign intOut  = armed && qualHit;

  always_comb begin
    isrNext = isr;
    if (st.eoiClr && svcHit) isrNext[svcLvl] = 1'b0;
    if (st.ackTake && qualHit) isrNext[bestLvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr      <= '0;
      imr      <= '0;
      isr      <= '0;
      vecBase  <= '0;
      takenLvl <= '0;
      vecValid <= 1'b0;
      vecData  <= '0;
    end else begin
      irr <= irqIn;
      if (st.ackTake && qualHit) irr[bestLvl] <= 1'b0;

      if (st.cfgStart) begin
        imr <= '0;
        isr <= '0;
      end else begin
        if (st.maskWr) imr <= wrData[N_IRQ-1:0];
        isr <= isrNext;
      end

      if (st.baseWr) vecBase <= wrData[VEC_W-1:LVL_W];
      if (st.ackTake) takenLvl <= qualHit ? bestLvl : LVL_W'(N_IRQ - 1);

      vecValid <= st.ackEmit;
      if (st.ackEmit) vecData <= {vecBase, takenLvl};
    end
  end

  assign rdData = regAddr ? imr : (readIsr ? isr : irr);

  // R6: an accepted acknowledge leaves a level in service
  p_take_marks_isr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.ackTake && qualHit && !st.cfgStart) |=> (isr != '0));
  // R8: end-of-service removes exactly one level
  p_eoi_drops_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.eoiClr && svcHit && !st.ackTake && !st.cfgStart)
      |=> ($countones(isr) == $countones($past(isr)) - 1));
  // R9: setup start wipes mask and service state
  p_cfg_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.cfgStart |=> (imr == '0 && isr == '0));
  // R4: the output never rises on masked requests alone
  p_int_needs_unmasked_r4: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irr & ~imr) != '0));
  // R7: the vector is a one-clock pulse
  p_vec_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

endmodule

// File: rtl/irq_prio_merger.sv
module irq_prio_merger
  import irq_prio_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_IRQ-1:0] irqIn,
  output logic             intOut,
  input  logic             ackStrobe,
  input  logic             wrEn,
  input  logic             regAddr,
  input  logic [VEC_W-1:0] wrData,
  output logic [N_IRQ-1:0] rdData,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecData
);

  ctrlStrobeT st;
  logic       armed;
  logic       readIsr;

  irq_prio_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .ackStrobe(ackStrobe), .st(st),
    .armed(armed), .readIsr(readIsr)
  );

  irq_prio_dp #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .armed(armed), .readIsr(readIsr),
    .regAddr(regAddr), .wrData(wrData), .irqIn(irqIn), .intOut(intOut),
    .rdData(rdData), .vecValid(vecValid), .vecData(vecData)
  );

  // R2: nothing is signalled while unarmed
  p_quiet_unarmed_r2: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !intOut);

endmodule

// File: tb/tb_irq_prio_merger.sv
module tb_irq_prio_merger;

  localparam int K_INT = 0, K_NOVEC = 1, K_VEC = 2, K_RD = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       intOut;
  logic       ackStrobe = 1'b0;
  logic       wrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       vecValid;
  logic [7:0] vecData;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] exp;
    string      tag;
  } expT;

  expT sb[$];
  int  cyc = 0;
  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  irq_prio_merger dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .intOut(intOut),
    .ackStrobe(ackStrobe), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .vecValid(vecValid), .vecData(vecData)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int dly, input int kind, input logic [7:0] exp,
                      input string tag);
    expT e;
    e.due = cyc + dly; e.kind = kind; e.exp = exp; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: checks each due item 1 ns before the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          logic [7:0] got;
          logic       ok;
          case (sb[i].kind)
            K_INT:   begin got = {7'd0, intOut};   ok = (got == sb[i].exp); end
            K_NOVEC: begin got = {7'd0, vecValid}; ok = (vecValid == 1'b0); end
            K_VEC:   begin got = vecValid ? vecData : 8'hxx;
                           ok = vecValid && (vecData == sb[i].exp); end
            default: begin got = rdData;           ok = (got == sb[i].exp); end
          endcase
          total++;
          if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", sb[i].tag, got, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    tick(); wrEn = 1'b1; regAddr = a; wrData = d;
    tick(); wrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic rdChk(input logic a, input logic [7:0] exp, input string tag);
    regAddr = a; push(0, K_RD, exp, tag);
    tick(); regAddr = 1'b0;
  endtask

  task automatic setIrq(input logic [7:0] v, input logic expInt, input string tag);
    tick(); irqIn = v; push(1, K_INT, {7'd0, expInt}, tag);
    tick();
  endtask

  task automatic ackPair(input logic [7:0] expVec, input string tag);
    tick(); ackStrobe = 1'b1;
    push(1, K_NOVEC, 8'h00, {tag, " first strobe, no vector"});
    push(1, K_INT, 8'h00, {tag, " int drops after take"});
    push(2, K_VEC, expVec, tag);
    push(3, K_NOVEC, 8'h00, {tag, " vector one clock"});
    tick(); tick(); ackStrobe = 1'b0;
    tick(); tick();
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rstN = 1'b1;
    tick();
    // R1 reset state
    push(0, K_INT, 8'h00, "R1 intOut after reset");
    push(0, K_NOVEC, 8'h00, "R1 vecValid after reset");
    rdChk(1'b1, 8'h00, "R1 mask reads zero");
    rdChk(1'b0, 8'h00, "R1 request reads zero");

    // R2 requests ignored before setup
    setIrq(8'h01, 1'b0, "R2 no int before setup");

    // R10 four-word variant: single, fourth word wanted
    wr(1'b0, 8'h13);
    push(0, K_INT, 8'h00, "R2 still quiet after word 1");
    wr(1'b1, 8'h40);
    push(0, K_INT, 8'h00, "R10 waits for fourth word");
    wr(1'b1, 8'h01);
    push(0, K_INT, 8'h01, "R3 int after setup with line 0 high");

    // R6/R7 acknowledge line 0
    ackPair(8'h40, "R7 vector for line 0");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h01, "R11 isr select shows line 0");

    // R5 lower level blocked by level in service
    setIrq(8'h05, 1'b0, "R5 line 2 below level 0");
    setIrq(8'h04, 1'b0, "R5 line 2 alone still blocked");
    wr(1'b0, 8'h20);
    push(0, K_INT, 8'h01, "R8 eoi frees line 2");
    rdChk(1'b0, 8'h00, "R8 isr empty after eoi");

    // R4 masking
    wr(1'b1, 8'h04);
    push(0, K_INT, 8'h00, "R4 masked line 2 quiet");
    rdChk(1'b1, 8'h04, "R11 mask readback");
    wr(1'b1, 8'h00);
    push(0, K_INT, 8'h01, "R4 unmasked line 2 raises int");

    // R5 nesting: line 2 in service, line 1 preempts
    ackPair(8'h42, "R7 vector for line 2");
    rdChk(1'b0, 8'h04, "R6 isr holds line 2");
    setIrq(8'h06, 1'b1, "R5 line 1 outranks line 2");
    ackPair(8'h41, "R7 vector for line 1");
    rdChk(1'b0, 8'h06, "R6 isr holds lines 1 and 2");
    wr(1'b0, 8'h20);
    rdChk(1'b0, 8'h04, "R8 eoi clears line 1 first");
    wr(1'b0, 8'h0A);
    rdChk(1'b0, 8'h06, "R11 request select readback");
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h20);
    rdChk(1'b0, 8'h00, "R8 second eoi clears line 2");
    push(0, K_INT, 8'h01, "R3 line 1 pending again");

    // R9 restart clears state; R10 two-word variant
    ackPair(8'h41, "R7 vector before restart");
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h12);
    push(0, K_INT, 8'h00, "R9 quiet during restart");
    rdChk(1'b1, 8'h00, "R9 mask cleared");
    wr(1'b1, 8'h80);
    push(0, K_INT, 8'h01, "R10 two words arm the block");
    rdChk(1'b0, 8'h06, "R9 read select back to request");
    wr(1'b0, 8'h0B);
    rdChk(1'b0, 8'h00, "R9 isr cleared");
    ackPair(8'h81, "R7 vector with new base");

    // R10 three-word variant: cascade bit clear, no fourth word
    wr(1'b0, 8'h10);
    wr(1'b1, 8'hC0);
    push(0, K_INT, 8'h00, "R10 waits for third word");
    wr(1'b1, 8'h00);
    push(0, K_INT, 8'h01, "R10 three words arm the block");
    ackPair(8'hC1, "R7 vector after three words");

    tick(); tick(); tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule